// File: doc/BRIEF.md
# Multiplexed Address/Data Local Bus Master

This block runs one access at a time on a shared 32-bit address/data bus toward an external RAM-style device. A client inside the chip offers a request through a valid/ready pair. The request carries an address, write data, a direction flag and a port width of 8, 16 or 32 bits. The block then runs a fixed sequence. First comes an address cycle with the latch strobe high. Next is a hold cycle in which the address stays on the bus with the strobe low. Last is a data phase with a programmable length, in which the block either drives write data or releases the bus so the device can drive read data. A single-cycle completion pulse returns the read data and a parity-error flag for each byte lane.

Next to the shared bus, the block drives the five low address bits on dedicated pins, with no latching needed. It produces a parity bit for each byte lane, with even or odd sense chosen by configuration. It also drives a direction line for an external data transceiver. That line stays high outside read data phases and can be forced high permanently. Pad tristate buffers sit outside the block, so each bus has separate out, output-enable and in signals. Bus bit 31 is the most significant bit, and bits 31:24 form the byte lane at address offset 0.

Top module: `lbus_mux_master`

## Requirements
- R1: After reset, `ale` is 0, `ad_oe` and `par_oe` are 0, `bctl` is 1, `req_ready` is 1 and `done` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no access is in progress. In the cycle after acceptance, `ale` is 1 for exactly that one cycle, and `ad_out` carries the full 32-bit address with `ad_oe` = 1.
- R3: In the cycle after the `ale` cycle, `ale` is 0, `ad_oe` stays 1 and `ad_out` still carries the address.
- R4: The data phase lasts W cycles, where W is `cfg_wait` captured at acceptance and a value of 0 counts as 1. After the last data cycle, `ad_oe` is 0 and `done` is 1 for exactly one cycle.
- R5: In a write data phase, `ad_oe` = 1 and the data lanes follow `req_size`. Size 0 (8-bit) puts wdata[7:0] on ad[31:24]. Size 1 (16-bit) puts wdata[15:0] on ad[31:16]. Sizes 2 and 3 (32-bit) put wdata[31:0] on ad[31:0]. Unused lanes are driven 0.
- R6: In a read data phase, `ad_oe` = 0 for every cycle. `ad_in` is sampled in the last data cycle. With `done`, `rdata` returns the used lanes right-aligned and zero-extended: ad[31:24], ad[31:16] or ad[31:0].
- R7: `la` equals bits 4:0 of the most recently accepted address from the `ale` cycle onward. It is 0 before the first access.
- R8: `par_oe` equals `ad_oe` in every cycle. `par_out[i]` covers ad[31-8i : 24-8i]. With `cfg_odd_par` = 0 (even), the lane byte and its parity bit together hold an even number of ones. With 1 (odd), they hold an odd number. The parity sense is captured at acceptance.
- R9: On a read, `perr[i]` is 1 only when lane i is used by the port size and `par_in[i]`, sampled with the data, does not match the expected parity. Lanes the port size does not use report 0 whatever their parity. Writes return `perr` = 0.
- R10: `bctl` is 1 when idle and in the address and hold cycles. In data cycles it is 1 for a write and 0 for a read. While `cfg_bctl_off` = 1, `bctl` is 1 in every cycle.
- R11: A request offered during the `done` cycle is accepted there, so its `ale` cycle follows directly. A request held high during a busy access is not accepted until the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Block idle, request may be taken |
| req_addr | input | 32 | Access address |
| req_wdata | input | 32 | Write data, right-aligned |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Port width: 0 = 8, 1 = 16, 2/3 = 32 bits |
| cfg_wait | input | 4 | Data phase length in cycles (0 acts as 1) |
| cfg_odd_par | input | 1 | 1 = odd parity, 0 = even |
| cfg_bctl_off | input | 1 | Forces buffer control high |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, right-aligned |
| perr | output | 4 | Per-lane read parity error |
| ale | output | 1 | Address latch strobe |
| ad_out | output | 32 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 32 | Shared bus input value |
| par_out | output | 4 | Lane parity output |
| par_oe | output | 1 | Parity pins output enable |
| par_in | input | 4 | Lane parity input |
| la | output | 5 | Unlatched low address bits |
| bctl | output | 1 | Data transceiver direction control |

## Verification
The completion pulse of one access and the acceptance of the next can land in the same cycle. The bench provokes this by offering each new request at the first cycle where `req_ready` is seen high, which is the `done` cycle of the previous access. It also holds `req_valid` high across a whole busy access. On every clock, a behavioural model tracks the cycle count since acceptance. It requires that `rdata`/`perr` for the old access and `ale` with the new address in the next cycle both appear exactly on time. Parity faults are injected on used and on unused lanes to separate real errors from undefined lanes.

// File: rtl/lbus_mux_master.sv
module lbus_mux_master #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_odd_par,
  input  logic              cfg_bctl_off,
  output logic              done,
  output logic [31:0]       rdata,
  output logic [3:0]        perr,
  output logic              ale,
  output logic [31:0]       ad_out,
  output logic              ad_oe,
  input  logic [31:0]       ad_in,
  output logic [3:0]        par_out,
  output logic              par_oe,
  input  logic [3:0]        par_in,
  output logic [4:0]        la,
  output logic              bctl
);

  localparam int LANES = 4;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_HOLD, S_DATA} st_t;

  st_t               st;
  logic [31:0]       addr_q, wdata_q;
  logic              wr_q, odd_q;
  logic [1:0]        size_q;
  logic [WAIT_W-1:0] cnt;
  logic [31:0]       wr_bus, rd_data;
  logic [3:0]        used, rd_perr;

  always_comb begin
    case (size_q)
      2'd0:    begin used = 4'b0001; wr_bus = {wdata_q[7:0], 24'h0};  rd_data = {24'h0, ad_in[31:24]}; end
      2'd1:    begin used = 4'b0011; wr_bus = {wdata_q[15:0], 16'h0}; rd_data = {16'h0, ad_in[31:16]}; end
      default: begin used = 4'b1111; wr_bus = wdata_q;                rd_data = ad_in;                 end
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign ale       = (st == S_ADDR);
  assign ad_oe     = (st == S_ADDR) || (st == S_HOLD) || (st == S_DATA && wr_q);
  assign par_oe    = ad_oe;
  assign ad_out    = (st == S_ADDR || st == S_HOLD) ? addr_q : wr_bus;
  assign la        = addr_q[4:0];
  assign bctl      = cfg_bctl_off || (st != S_DATA) || wr_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par_out[i] = (^ad_out[31-8*i -: 8]) ^ odd_q;
    assign rd_perr[i] = used[i] & ((^ad_in[31-8*i -: 8]) ^ par_in[i] ^ odd_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      odd_q   <= 1'b0;
      size_q  <= 2'd2;
      cnt     <= '0;
      done    <= 1'b0;
      rdata   <= '0;
      perr    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          size_q  <= req_size;
          odd_q   <= cfg_odd_par;
          cnt     <= (cfg_wait == '0) ? WAIT_W'(1) : cfg_wait;
          st      <= S_ADDR;
        end
        S_ADDR: st <= S_HOLD;
        S_HOLD: st <= S_DATA;
        S_DATA: if (cnt == WAIT_W'(1)) begin
          st   <= S_IDLE;
          done <= 1'b1;
          perr <= wr_q ? 4'b0 : rd_perr;
          if (!wr_q) rdata <= rd_data;
        end else begin
          cnt <= cnt - WAIT_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && ad_oe));
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && $stable(ad_out) && bctl));
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ad_oe && req_ready));
  a_r11_accept_to_ale: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ale);
  a_r9_unused_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((perr & ~used) == 4'b0));
  a_r10_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    !bctl |-> !ad_oe);

endmodule

// File: tb/lbus_mux_master_tb.sv
`timescale 1ns/1ps
module lbus_mux_master_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, cfg_odd_par = 0, cfg_bctl_off = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, ad_in = 0;
  logic [1:0] req_size = 0;
  logic [3:0] cfg_wait = 1, par_in = 0;
  logic req_ready, done, ale, ad_oe, par_oe, bctl;
  logic [31:0] rdata, ad_out;
  logic [3:0] perr, par_out;
  logic [4:0] la;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lbus_mux_master dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write), .req_size(req_size),
    .cfg_wait(cfg_wait), .cfg_odd_par(cfg_odd_par), .cfg_bctl_off(cfg_bctl_off),
    .done(done), .rdata(rdata), .perr(perr), .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .par_out(par_out), .par_oe(par_oe), .par_in(par_in), .la(la), .bctl(bctl));

  // behavioural model: cycles since acceptance
  int m_cyc = 0, m_w = 1;
  logic [31:0] m_addr = 0, m_wdata = 0, m_rdata = 0;
  logic m_wr = 0, m_odd = 0, m_done = 0;
  logic [1:0] m_size = 2;
  logic [3:0] m_perr = 0;

  function automatic logic par8(logic [7:0] b, logic odd);
    return logic'($countones(b) % 2) ^ odd;
  endfunction

  function automatic int lanes_of(logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc <= 0; m_done <= 0; m_addr <= 0; m_rdata <= 0; m_perr <= 0;
    end else begin
      m_done <= 0;
      if (m_cyc == 0) begin
        if (req_valid) begin
          m_cyc <= 1; m_addr <= req_addr; m_wdata <= req_wdata; m_wr <= req_write;
          m_size <= req_size; m_odd <= cfg_odd_par; m_w <= (cfg_wait == 0) ? 1 : int'(cfg_wait);
        end
      end else if (m_cyc == 2 + m_w) begin
        logic [3:0] pe;
        logic [31:0] rd;
        m_cyc <= 0; m_done <= 1;
        pe = 0;
        for (int i = 0; i < lanes_of(m_size); i++)
          if (par_in[i] != par8(ad_in[31-8*i -: 8], m_odd)) pe[i] = 1;
        rd = ad_in >> (32 - 8 * lanes_of(m_size));
        if (lanes_of(m_size) == 4) rd = ad_in;
        if (!m_wr) begin m_rdata <= rd; m_perr <= pe; end
        else m_perr <= 0;
      end else m_cyc <= m_cyc + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      logic e_ale, e_oe, e_bctl;
      logic [31:0] e_ad;
      logic [3:0] e_par;
      if (!rst_n) begin
        chk(ale == 0 && ad_oe == 0 && par_oe == 0, "R1", "reset drive", {ale, ad_oe, par_oe}, 0);
      end else begin
        e_ale = (m_cyc == 1);
        e_oe = (m_cyc == 1) || (m_cyc == 2) || (m_cyc >= 3 && m_wr);
        e_bctl = cfg_bctl_off || m_cyc < 3 || m_wr;
        if (m_cyc == 1 || m_cyc == 2) e_ad = m_addr;
        else if (lanes_of(m_size) == 1) e_ad = {m_wdata[7:0], 24'h0};
        else if (lanes_of(m_size) == 2) e_ad = {m_wdata[15:0], 16'h0};
        else e_ad = m_wdata;
        for (int i = 0; i < 4; i++) e_par[i] = par8(e_ad[31-8*i -: 8], m_odd);
        chk(req_ready == (m_cyc == 0), "R2", "req_ready", req_ready, m_cyc == 0);
        chk(ale == e_ale, "R2", "ale", ale, e_ale);
        chk(ad_oe == e_oe, "R4", "ad_oe", ad_oe, e_oe);
        chk(par_oe == e_oe, "R8", "par_oe", par_oe, e_oe);
        chk(done == m_done, "R4", "done", done, m_done);
        chk(bctl == e_bctl, "R10", "bctl", bctl, e_bctl);
        chk(la == m_addr[4:0], "R7", "la", la, m_addr[4:0]);
        if (e_oe) begin
          chk(ad_out == e_ad, (m_cyc < 3) ? "R3" : "R5", "ad_out", ad_out, e_ad);
          chk(par_out == e_par, "R8", "par_out", par_out, e_par);
        end
        if (m_done) begin
          chk(perr == m_perr, "R9", "perr", perr, m_perr);
          if (!m_wr) chk(rdata == m_rdata, "R6", "rdata", rdata, m_rdata);
        end
      end
    end
  end

  task automatic access(logic wr, logic [31:0] a, logic [31:0] d, logic [1:0] sz,
                        logic [3:0] w, logic odd, logic [31:0] din, logic [3:0] pin);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
    cfg_wait = w; cfg_odd_par = odd; ad_in = din; par_in = pin;
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~d;
    cfg_wait = w + 4'd5; cfg_odd_par = ~odd;
  endtask

  function automatic logic [3:0] good_par(logic [31:0] v, logic odd);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = par8(v[31-8*i -: 8], odd);
    return p;
  endfunction

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && bctl == 1 && done == 0, "R1", "reset ready/bctl/done",
        {req_ready, bctl, done}, 3'b110);
    rst_n = 1;
    // R5 writes at each size, R4 wait lengths including 0
    access(1, 32'hA5C3_1F07, 32'h1234_5678, 2, 1, 0, 0, 0);
    access(1, 32'h0000_0013, 32'hFFFF_BEEF, 1, 3, 1, 0, 0);
    access(1, 32'h8000_001E, 32'hCAFE_F00D, 0, 0, 0, 0, 0);
    access(1, 32'h7777_0001, 32'h0F0F_F0F0, 3, 15, 1, 0, 0);
    // R6/R9 reads
    access(0, 32'h4000_0004, 0, 2, 2, 0, 32'hDEAD_BEEF, good_par(32'hDEAD_BEEF, 0));
    access(0, 32'h4000_0008, 0, 2, 1, 1, 32'h0102_0304, good_par(32'h0102_0304, 1) ^ 4'b0100);
    access(0, 32'h4000_0009, 0, 0, 2, 0, 32'h5A11_2233, good_par(32'h5A11_2233, 0) ^ 4'b1110);
    access(0, 32'h4000_000A, 0, 0, 1, 1, 32'h8311_2233, good_par(32'h8311_2233, 1) ^ 4'b0001);
    access(0, 32'h4000_000C, 0, 1, 4, 0, 32'h6789_ABCD, good_par(32'h6789_ABCD, 0) ^ 4'b1010);
    // R10 buffer control disabled on a read
    cfg_bctl_off = 1;
    access(0, 32'h4000_0010, 0, 1, 2, 1, 32'h1357_9BDF, good_par(32'h1357_9BDF, 1));
    access(1, 32'h4000_0014, 32'h2468_ACE0, 2, 1, 0, 0, 0);
    cfg_bctl_off = 0;
    // R11: valid held high across busy accesses
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 32'h0000_001F; req_size = 2; cfg_wait = 2;
    ad_in = 32'hFEDC_BA98; par_in = good_par(32'hFEDC_BA98, 0); cfg_odd_par = 0;
    repeat (12) @(negedge clk);
    req_valid = 0;
    repeat (25) @(negedge clk);
    finished = 1;
    report();
    $finish;
  end
endmodule